// File: doc/BRIEF.md
# Late-Operand Carry-Select Adder

This block adds two unsigned operands and returns a sum of fixed width `W`. One operand is wide and settles early. The other is narrow (`K` bits) and settles late. The sum is wrapped to `W` bits.

The late operand passes through only a `K`-bit adder and one two-way multiplexer. That adder takes the low `K` bits of the zero-extended wide operand. The upper `W-K` result bits are prepared in parallel from the wide operand alone, in two versions: unchanged, and plus one. The carry out of the low adder selects between the two versions.

The block has no clock and no state. It is placed in a path where the narrow operand sets the critical timing. Elaboration stops if the parameters violate any of the following rules:
- `1 <= K < W`
- `K <= WIDE_W <= W`
- `K <= MAX_NARROW`
- `W-K >= MIN_HIGH`

Top module: `late_csel_add`

## Requirements
- R1: `sum_o` equals `(wide_i + narrow_i) mod 2^W` for every pair of input values.
- R2: `sum_o[K-1:0]` equals `(wide_i[K-1:0] + narrow_i) mod 2^K`.
- R3: When `wide_i[K-1:0] + narrow_i < 2^K`, `sum_o[W-1:K]` equals bits `[W-1:K]` of the zero-extended wide operand, unchanged.
- R4: When `wide_i[K-1:0] + narrow_i >= 2^K`, `sum_o[W-1:K]` equals the upper bits plus one, modulo `2^(W-K)`. All-ones upper bits wrap to zero.
- R5: When `WIDE_W < W`, the wide operand is zero-extended before the split. Result bits at or above `WIDE_W` are set only by a carry that propagates up from lower bits.
- R6: When `narrow_i` is zero, `sum_o` equals the zero-extended `wide_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wide_i | input | WIDE_W | Early-arriving wide unsigned operand |
| narrow_i | input | K | Late-arriving narrow unsigned operand |
| sum_o | output | W | Sum modulo 2^W |

## Verification
The hardest case is an incrementer wrap, because it needs two conditions at once. The low half must produce a carry, and every upper bit of the wide operand must be one. Random operands almost never produce this.

The stimulus table therefore pairs all-ones upper bits with low bits that sit just at, or just below, the carry threshold. These vectors hit the wrap and its neighbour directly.

A second instance with a narrower wide operand reaches the zero-extension boundary. A carry there must ripple into bits that the operand never drives.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int unsigned INC_BEHAV = 0;
  localparam int unsigned INC_CHAIN = 1;

  function automatic bit lcs_params_ok(int unsigned w, int unsigned wide_w, int unsigned k,
                                       int unsigned max_narrow, int unsigned min_high);
    return (k >= 1) && (k < w) && (k <= wide_w) && (wide_w <= w) &&
           (k <= max_narrow) && ((w - k) >= min_high);
  endfunction
endpackage

// File: rtl/lcs_low_add.sv
module lcs_low_add #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  output logic [K-1:0] sum_o,
  output logic         cout_o
);
  logic [K:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o  = full[K-1:0];
  assign cout_o = full[K];
endmodule

// File: rtl/lcs_hi_inc.sv
module lcs_hi_inc #(
  parameter int unsigned HW        = 24,
  parameter int unsigned INC_STYLE = 1
) (
  input  logic [HW-1:0] hi_i,
  output logic [HW-1:0] inc_o
);
  generate
    if (INC_STYLE == lcs_pkg::INC_BEHAV) begin : g_behav
      assign inc_o = hi_i + HW'(1);
    end else begin : g_chain
      // propagate-only chain: bit i flips when all lower bits are one
      logic [HW-1:0] prop;
      assign prop[0] = 1'b1;
      for (genvar i = 1; i < HW; i++) begin : g_prop
        assign prop[i] = prop[i-1] & hi_i[i-1];
      end
      assign inc_o = hi_i ^ prop;
    end
  endgenerate
endmodule

// File: rtl/lcs_hi_sel.sv
module lcs_hi_sel #(
  parameter int unsigned HW = 24
) (
  input  logic          sel_i,
  input  logic [HW-1:0] plain_i,
  input  logic [HW-1:0] inc_i,
  output logic [HW-1:0] hi_o
);
  assign hi_o = sel_i ? inc_i : plain_i;
endmodule

// File: rtl/late_csel_add.sv
module late_csel_add #(
  parameter int unsigned W          = 32,
  parameter int unsigned WIDE_W     = 32,
  parameter int unsigned K          = 8,
  parameter int unsigned MAX_NARROW = 16,
  parameter int unsigned MIN_HIGH   = 8,
  parameter int unsigned INC_STYLE  = lcs_pkg::INC_CHAIN
) (
  input  logic [WIDE_W-1:0] wide_i,
  input  logic [K-1:0]      narrow_i,
  output logic [W-1:0]      sum_o
);
  localparam int unsigned HW = W - K;

  generate
    if (!lcs_pkg::lcs_params_ok(W, WIDE_W, K, MAX_NARROW, MIN_HIGH)) begin : g_bad_params
      $error("late_csel_add: illegal W/WIDE_W/K combination");
    end
  endgenerate

  logic [W-1:0]  wide_ext;
  logic [K-1:0]  lo_sum;
  logic          lo_carry;
  logic [HW-1:0] hi_plain;
  logic [HW-1:0] hi_inc;
  logic [HW-1:0] hi_sel;

  assign wide_ext = W'(wide_i);
  assign hi_plain = wide_ext[W-1:K];

  lcs_low_add #(.K(K)) u_low (
    .a_i   (wide_ext[K-1:0]),
    .b_i   (narrow_i),
    .sum_o (lo_sum),
    .cout_o(lo_carry)
  );

  lcs_hi_inc #(.HW(HW), .INC_STYLE(INC_STYLE)) u_inc (
    .hi_i (hi_plain),
    .inc_o(hi_inc)
  );

  lcs_hi_sel #(.HW(HW)) u_sel (
    .sel_i  (lo_carry),
    .plain_i(hi_plain),
    .inc_i  (hi_inc),
    .hi_o   (hi_sel)
  );

  assign sum_o = {hi_sel, lo_sum};
endmodule

// File: rtl/late_csel_add_chk.sv
module late_csel_add_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned WIDE_W = 32,
  parameter int unsigned K      = 8
) (
  input logic [WIDE_W-1:0] wide_i,
  input logic [K-1:0]      narrow_i,
  input logic [W-1:0]      sum_o,
  input logic              lo_carry
);
  localparam int unsigned HW = W - K;
  logic [W-1:0]  w_ext;
  logic [K:0]    lo_ref;
  logic [HW-1:0] hi_ref;

  always_comb begin
    w_ext  = W'(wide_i);
    lo_ref = {1'b0, w_ext[K-1:0]} + {1'b0, narrow_i};
    hi_ref = w_ext[W-1:K];
    assert_full_sum_R1: assert (sum_o == W'(w_ext + W'(narrow_i)));
    assert_low_bits_R2: assert (sum_o[K-1:0] == lo_ref[K-1:0]);
    assert_carry_R4: assert (lo_carry == lo_ref[K]);
    if (!lo_ref[K]) begin
      assert_hi_plain_R3: assert (sum_o[W-1:K] == hi_ref);
    end else begin
      assert_hi_inc_R4: assert (sum_o[W-1:K] == HW'(hi_ref + HW'(1)));
    end
    if (narrow_i == '0) begin
      assert_zero_narrow_R6: assert (sum_o == w_ext);
    end
  end
endmodule

bind late_csel_add late_csel_add_chk #(.W(W), .WIDE_W(WIDE_W), .K(K)) u_chk (
  .wide_i  (wide_i),
  .narrow_i(narrow_i),
  .sum_o   (sum_o),
  .lo_carry(lo_carry)
);

// File: tb/tb_late_csel_add.sv
module tb_late_csel_add;
  localparam int unsigned W  = 32;
  localparam int unsigned K  = 8;
  localparam int unsigned XW = 20;
  localparam int unsigned NV = 10;

  // {wide, narrow, expected}
  localparam logic [71:0] VEC [NV] = '{
    {32'h00000000, 8'h00, 32'h00000000},
    {32'h000000FF, 8'h01, 32'h00000100},
    {32'hFFFFFFFF, 8'h01, 32'h00000000},
    {32'hFFFFFF00, 8'hFF, 32'hFFFFFFFF},
    {32'h12345678, 8'h88, 32'h12345700},
    {32'h12345678, 8'h07, 32'h1234567F},
    {32'h00FFFF80, 8'h80, 32'h01000000},
    {32'hFFFFFF01, 8'hFE, 32'hFFFFFFFF},
    {32'hFFFFFF02, 8'hFE, 32'h00000000},
    {32'hA5A5A5A5, 8'h5A, 32'hA5A5A5FF}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]  wide;
  logic [K-1:0]  narrow;
  logic [W-1:0]  sum;
  logic [XW-1:0] xwide;
  logic [K-1:0]  xnarrow;
  logic [W-1:0]  xsum;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  late_csel_add #(.W(W), .WIDE_W(W), .K(K)) dut (
    .wide_i(wide), .narrow_i(narrow), .sum_o(sum)
  );

  late_csel_add #(.W(W), .WIDE_W(XW), .K(K), .INC_STYLE(0)) dut_ext (
    .wide_i(xwide), .narrow_i(xnarrow), .sum_o(xsum)
  );

  task automatic cmp(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [K-1:0] b);
    @(negedge clk);
    wide = a; narrow = b;
    #1;
  endtask

  task automatic apply_ext(logic [XW-1:0] a, logic [K-1:0] b);
    @(negedge clk);
    xwide = a; xnarrow = b;
    #1;
  endtask

  initial begin
    wide = '0; narrow = '0; xwide = '0; xnarrow = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    cmp("R6 idle", sum, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][71:40], VEC[i][39:32]);
      cmp("R1 table", sum, VEC[i][31:0]);
    end

    // R2/R3: low bits and no-carry path
    apply(32'hDEADBE10, 8'h0F);
    cmp("R2 low", {24'h0, sum[7:0]}, 32'h1F);
    cmp("R3 hi plain", {8'h0, sum[31:8]}, 32'h00DEADBE);
    // R4: carry and wrap
    apply(32'hDEADBEF0, 8'h10);
    cmp("R4 hi inc", {8'h0, sum[31:8]}, 32'h00DEADBF);
    apply(32'hFFFFFFF0, 8'h10);
    cmp("R4 wrap", sum, 32'h0);
    // R6: zero narrow
    apply(32'hCAFEF00D, 8'h00);
    cmp("R6 passthru", sum, 32'hCAFEF00D);

    // R5: zero extension
    apply_ext(20'hFFFFF, 8'h01);
    cmp("R5 carry into ext", xsum, 32'h00100000);
    apply_ext(20'hFFFF0, 8'h0F);
    cmp("R5 no carry", xsum, 32'h000FFFFF);
    apply_ext(20'h12345, 8'h00);
    cmp("R5 zero narrow", xsum, 32'h00012345);

    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0]  ra;
      logic [K-1:0]  rb;
      logic [XW-1:0] rx;
      ra = $urandom;
      rb = K'($urandom);
      rx = XW'($urandom);
      if (n % 4 == 1) ra[7:0] = 8'hFF;
      if (n % 4 == 2) ra[31:8] = 24'hFFFFFF;
      apply(ra, rb);
      cmp("R1 random", sum, ra + {24'h0, rb});
      apply_ext(rx, rb);
      cmp("R5 random", xsum, {12'h0, rx} + {24'h0, rb});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule